// File: doc/BRIEF.md
# Bidirectional Parallel Printer Port

This block is a printer-style parallel port. It has an 8-bit data path that can be turned around, four control outputs toward the printer, five status inputs from it, and an interrupt taken from the printer's acknowledge line. A host processor reaches it through four byte-wide registers, selected by a 2-bit address, with separate read and write strobes qualified by a chip select. Everything runs synchronously on one clock. Each clock cycle in which select and a strobe are both high counts as an access.

The interrupt is latched. While interrupts are enabled, an acknowledge from the printer sets a pending flag. That flag survives the release of acknowledge and is dropped only by an access to the data register, or by turning the enable off. The interrupt pin is modelled as an output-enable so that the line can be shared by several devices. The port-direction bit cannot be read back in the control register; it appears in a second status register, next to the pending flag.

Top module: `lpt_port_top`

## Requirements
- R1: A write to address 0 in output mode (direction bit 0) places the written byte on `pd_out` one clock later.
- R2: A write to address 0 in input mode (direction bit 1) is discarded: `pd_out` keeps its old value, and that value is still there when the port returns to output mode.
- R3: A read of address 0 returns `pd_in` in input mode and the driven latch value in output mode.
- R4: A read of address 1 returns {busy, ack_n, paper_out, select, error, 3'b000} (bit 7 down to bit 0). Writes to address 1 change nothing.
- R5: A write to address 2 sets strobe (bit 0), autofeed (bit 1), init (bit 2), select-printer (bit 3), interrupt enable (bit 4, 1 = enabled) and direction (bit 5, 1 = input). A read of address 2 returns bits 4:0 as written, with bits 7:5 reading 0.
- R6: A read of address 3 returns {pending, ack_n, paper_out, select, error, 2'b00, direction}.
- R7: `pd_oe` is high exactly while the direction bit is 0.
- R8: While interrupts are enabled, an asserted acknowledge (pin low) sets the pending flag. The flag stays set after acknowledge is released.
- R9: A read or write of address 0 clears the pending flag, unless acknowledge is still asserted, in which case the flag stays set.
- R10: Writing 0 to control bit 4 clears the pending flag and keeps it clear while acknowledge is asserted.
- R11: `irq_oe` is high exactly while the pending flag is set.
- R12: While `rst_n` is low, all control outputs and `pd_out` are 0, `pd_oe` is 1, `irq_oe` is 0, and host accesses have no effect.
- R13: `host_bus_dir` is high only while `host_cs` and `host_rd` are both high and reset is released.
- R14: Each status input passes through two flip-flops, so a change appears in a register read after two clock edges and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Chip select, active high |
| host_rd | input | 1 | Read strobe, active high |
| host_wr | input | 1 | Write strobe, active high |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Write data from host |
| host_rdata | output | 8 | Read data to host, 0 when not reading |
| host_bus_dir | output | 1 | External host transceiver toward host |
| irq_oe | output | 1 | Drive the shared interrupt line low |
| pd_out | output | 8 | Value driven on the port data pins |
| pd_in | input | 8 | Value sampled on the port data pins |
| pd_oe | output | 1 | Port data pin output enable |
| strobe_o | output | 1 | Strobe pin |
| autofeed_o | output | 1 | Autofeed pin |
| init_o | output | 1 | Init pin |
| selprn_o | output | 1 | Select-printer pin |
| err_i | input | 1 | Printer error |
| sel_i | input | 1 | Printer selected |
| pout_i | input | 1 | Paper out |
| ack_n_i | input | 1 | Acknowledge, asserted low |
| busy_i | input | 1 | Printer busy |

## Verification
The data path is tested with two distinct values. The latch and the external pins are given different contents, which shows whether a read takes the pin value or the latch value, and whether a write made in input mode reached the latch. The interrupt is tested with several acknowledge sequences: a pulse followed by a release, a data-register access made after the release, a data-register access made while acknowledge is still low, and a disable while acknowledge is low. Together these separate the flag's sticky behaviour, its clear, and the blocked-clear case. The status inputs are given a pattern whose bits differ from their neighbours, and the read is taken both after one edge and after two. This catches a mapping error or a wrong synchronizer depth.

// File: rtl/lpt_pkg.sv
// Shared constants for the parallel port: register addresses and the
// layout of the synchronized status vector.
package lpt_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int STAT_W = 5;

    localparam logic [ADDR_W-1:0] A_DATA  = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT2 = 2'd3;

    // Status vector positions (bit order follows register bits 7:3).
    localparam int S_ERR  = 0;
    localparam int S_SEL  = 1;
    localparam int S_POUT = 2;
    localparam int S_ACKN = 3;
    localparam int S_BUSY = 4;

    // Control register bit positions.
    localparam int C_STB  = 0;
    localparam int C_AFD  = 1;
    localparam int C_INIT = 2;
    localparam int C_SELP = 3;
    localparam int C_IEN  = 4;
    localparam int C_DIR  = 5;
endpackage

// File: rtl/lpt_in_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent. Reset loads RST_VAL into every stage.
module lpt_in_sync #(
    parameter int              WIDTH   = 5,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the vector one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)      stg[g] <= RST_VAL;
                else if (g == 0) stg[g] <= d_i;
                else             stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lpt_regs.sv
// Host-visible registers: data latch, control register and read mux.
// Assumes one access per cycle where cs and a strobe are high.
module lpt_regs
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pd_in,
    input  logic [STAT_W-1:0] stat,
    input  logic              pend,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] pd_q,
    output logic [5:0]        ctrl_q,
    output logic              ien_next,
    output logic              data_acc
);
    logic ctrl_we;
    logic data_we;
    logic dir;

    assign dir      = ctrl_q[C_DIR];
    assign ctrl_we  = wr_en && (addr == A_CTRL);
    assign data_we  = wr_en && (addr == A_DATA) && !dir;
    assign data_acc = (wr_en || rd_en) && (addr == A_DATA);
    assign ien_next = ctrl_we ? wdata[C_IEN] : ctrl_q[C_IEN];

    // Control register; only the six defined bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata[5:0];
    end

    // Output data latch; writes in input mode are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)       pd_q <= '0;
        else if (data_we) pd_q <= wdata;
    end

    // Read multiplexer, zero when no read is in progress.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_DATA:  rdata = dir ? pd_in : pd_q;
                A_STAT:  rdata = {stat, 3'b000};
                A_CTRL:  rdata = {3'b000, ctrl_q[4:0]};
                A_STAT2: rdata = {pend, stat[S_ACKN:S_ERR], 2'b00, dir};
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/lpt_irq.sv
// Sticky interrupt flag. Set by acknowledge while enabled, cleared by a
// data-register access when acknowledge is idle, or by disabling.
module lpt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en_next,
    input  logic ack_act,
    input  logic clr_acc,
    output logic pend
);
    // Priority: disable, then set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (!en_next) pend <= 1'b0;
        else if (ack_act) pend <= 1'b1;
        else if (clr_acc) pend <= 1'b0;
    end
endmodule

// File: rtl/lpt_port_top.sv
// Parallel printer port top: synchronizes status inputs, hosts the
// register file and the latched interrupt. Synchronous active-low reset.
module lpt_port_top
    import lpt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_bus_dir,
    output logic              irq_oe,
    output logic [DATA_W-1:0] pd_out,
    input  logic [DATA_W-1:0] pd_in,
    output logic              pd_oe,
    output logic              strobe_o,
    output logic              autofeed_o,
    output logic              init_o,
    output logic              selprn_o,
    input  logic              err_i,
    input  logic              sel_i,
    input  logic              pout_i,
    input  logic              ack_n_i,
    input  logic              busy_i
);
    localparam logic [STAT_W-1:0] STAT_RST = STAT_W'(1) << S_ACKN;

    logic [STAT_W-1:0] stat_raw, stat_s;
    logic              wr_en, rd_en;
    logic [5:0]        ctrl_q;
    logic [DATA_W-1:0] pd_q;
    logic              ien_next, data_acc, pend, ack_act;

    assign stat_raw = {busy_i, ack_n_i, pout_i, sel_i, err_i};
    assign wr_en    = rst_n && host_cs && host_wr;
    assign rd_en    = rst_n && host_cs && host_rd;
    assign ack_act  = !stat_s[S_ACKN];

    lpt_in_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES), .RST_VAL(STAT_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(stat_raw), .q_o(stat_s)
    );

    lpt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(host_addr), .wdata(host_wdata), .pd_in(pd_in), .stat(stat_s),
        .pend(pend), .rdata(host_rdata), .pd_q(pd_q), .ctrl_q(ctrl_q),
        .ien_next(ien_next), .data_acc(data_acc)
    );

    lpt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .en_next(ien_next), .ack_act(ack_act),
        .clr_acc(data_acc), .pend(pend)
    );

    assign host_bus_dir = rd_en;
    assign irq_oe       = pend;
    assign pd_out       = pd_q;
    assign pd_oe        = !ctrl_q[C_DIR];
    assign strobe_o     = ctrl_q[C_STB];
    assign autofeed_o   = ctrl_q[C_AFD];
    assign init_o       = ctrl_q[C_INIT];
    assign selprn_o     = ctrl_q[C_SELP];
endmodule

// File: rtl/lpt_port_checker.sv
// Protocol checks for lpt_port_top, attached with bind.
module lpt_port_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_cs,
    input logic       host_rd,
    input logic       host_wr,
    input logic [1:0] host_addr,
    input logic [7:0] host_wdata,
    input logic [7:0] pd_out,
    input logic       pd_oe,
    input logic       irq_oe,
    input logic       host_bus_dir,
    input logic       ack_act,
    input logic       ien
);
    logic dis_wr, dat_acc;
    assign dis_wr  = host_cs && host_wr && host_addr == 2'd2 && !host_wdata[4];
    assign dat_acc = host_cs && (host_rd || host_wr) && host_addr == 2'd0;

    // R2: data writes in input mode leave the latch unchanged.
    a_r2_input_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_wr && host_addr == 2'd0 && !pd_oe) |=> $stable(pd_out));

    // R8: pending flag is sticky while enabled and not cleared.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe && ien && !dat_acc && !dis_wr) |=> irq_oe);

    // R9: acknowledge held while enabled keeps the flag set.
    a_r9_ack_blocks_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_act && ien && !dis_wr && !(host_cs && host_wr && host_addr == 2'd2)) |=> irq_oe);

    // R10: disabling drops the interrupt.
    a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> !irq_oe);

    // R11: no interrupt drive while disabled.
    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq_oe);

    // R13: host transceiver turned only during a read.
    a_r13_bus_dir: assert property (@(posedge clk) disable iff (!rst_n)
        host_bus_dir |-> (host_cs && host_rd));
endmodule

bind lpt_port_top lpt_port_checker u_chk (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .pd_out(pd_out), .pd_oe(pd_oe), .irq_oe(irq_oe),
    .host_bus_dir(host_bus_dir), .ack_act(ack_act), .ien(ctrl_q[4])
);

// File: tb/lpt_port_top_bench.sv
`timescale 1ns/1ps
module lpt_port_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 0, host_rd = 0, host_wr = 0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_bus_dir, irq_oe, pd_oe;
    logic [7:0] pd_out;
    logic [7:0] pd_in = 8'h3C;
    logic       strobe_o, autofeed_o, init_o, selprn_o;
    logic       err_i = 0, sel_i = 0, pout_i = 0, ack_n_i = 1, busy_i = 0;
    int total = 0;
    int bad = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    lpt_port_top u_lpt_port_top (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_rd(host_rd),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_bus_dir(host_bus_dir), .irq_oe(irq_oe),
        .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe), .strobe_o(strobe_o),
        .autofeed_o(autofeed_o), .init_o(init_o), .selprn_o(selprn_o),
        .err_i(err_i), .sel_i(sel_i), .pout_i(pout_i), .ack_n_i(ack_n_i),
        .busy_i(busy_i)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_cs = 1; host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_cs = 0; host_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_cs = 1; host_rd = 1; host_addr = a;
        #0.5 d = host_rdata;
        @(negedge clk);
        host_cs = 0; host_rd = 0;
    endtask

    task automatic t_reset;
        rst_n = 0;
        wait_cyc(2);
        host_cs = 1; host_wr = 1; host_rd = 1; host_addr = 0; host_wdata = 8'hFF;
        wait_cyc(2);
        check("R12 pd_out in reset", pd_out, 8'h00);
        check("R13 bus_dir in reset", {7'd0, host_bus_dir}, 8'h00);
        host_cs = 0; host_wr = 0; host_rd = 0;
        wait_cyc(1);
        check("R12 outputs", {irq_oe, pd_oe, strobe_o, autofeed_o, init_o, selprn_o, 2'b00},
              8'b0100_0000);
        rst_n = 1;
        wait_cyc(1);
    endtask

    task automatic t_ctrl;
        wr(2'd2, 8'hEF);
        check("R5 pins", {4'd0, selprn_o, init_o, autofeed_o, strobe_o}, 8'h0F);
        rd(2'd2, rv); check("R5 readback hides 7:5", rv, 8'h0F);
        wr(2'd2, 8'h05);
        rd(2'd2, rv); check("R5 readback", rv, 8'h05);
        check("R5 pins low", {4'd0, selprn_o, init_o, autofeed_o, strobe_o}, 8'h05);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_data;
        wr(2'd0, 8'hA5);
        check("R1 pd_out", pd_out, 8'hA5);
        check("R7 oe output mode", {7'd0, pd_oe}, 8'h01);
        rd(2'd0, rv); check("R3 out-mode read", rv, 8'hA5);
        wr(2'd2, 8'h20);
        check("R7 oe input mode", {7'd0, pd_oe}, 8'h00);
        rd(2'd0, rv); check("R3 in-mode read", rv, 8'h3C);
        rd(2'd3, rv); check("R6 dir bit", rv & 8'h01, 8'h01);
        rd(2'd2, rv); check("R5 dir hidden", rv, 8'h00);
        wr(2'd0, 8'h77);
        check("R2 dropped", pd_out, 8'hA5);
        wr(2'd2, 8'h00);
        check("R2 latch kept", pd_out, 8'hA5);
    endtask

    task automatic t_status;
        @(negedge clk);
        err_i = 1; sel_i = 0; pout_i = 1; ack_n_i = 1; busy_i = 0;
        wait_cyc(3);
        rd(2'd1, rv); check("R4 pattern A", rv, 8'h68);
        rd(2'd3, rv); check("R6 pattern A", rv, 8'h68);
        wr(2'd1, 8'hFF);
        rd(2'd1, rv); check("R4 write ignored", rv, 8'h68);
        // one edge then read: value must still be old
        @(negedge clk);
        err_i = 0; sel_i = 1; pout_i = 0; busy_i = 1;
        host_cs = 1; host_rd = 1; host_addr = 2'd1;
        @(negedge clk); #0.5 rv = host_rdata;
        check("R14 after one edge", rv, 8'h68);
        @(negedge clk); #0.5 rv = host_rdata;
        check("R14 after two edges", rv, 8'hD0);
        host_cs = 0; host_rd = 0;
        wait_cyc(1);
    endtask

    task automatic t_irq;
        wr(2'd2, 8'h10);
        @(negedge clk); ack_n_i = 0;
        wait_cyc(4);
        check("R8 set", {7'd0, irq_oe}, 8'h01);
        check("R11 irq_oe", {7'd0, irq_oe}, 8'h01);
        ack_n_i = 1;
        wait_cyc(5);
        check("R8 sticky", {7'd0, irq_oe}, 8'h01);
        rd(2'd3, rv); check("R6 pending", rv & 8'h80, 8'h80);
        rd(2'd0, rv);
        wait_cyc(1);
        check("R9 cleared", {7'd0, irq_oe}, 8'h00);
        @(negedge clk); ack_n_i = 0;
        wait_cyc(4);
        wr(2'd0, 8'h11);
        wait_cyc(1);
        check("R9 ack held", {7'd0, irq_oe}, 8'h01);
        wr(2'd2, 8'h00);
        check("R10 disable clears", {7'd0, irq_oe}, 8'h00);
        wait_cyc(4);
        check("R10 blocked", {7'd0, irq_oe}, 8'h00);
        ack_n_i = 1;
        wait_cyc(3);
    endtask

    task automatic t_busdir;
        @(negedge clk);
        host_cs = 1; host_rd = 1; #0.5;
        check("R13 cs+rd", {7'd0, host_bus_dir}, 8'h01);
        host_rd = 0; #0.5;
        check("R13 cs only", {7'd0, host_bus_dir}, 8'h00);
        host_cs = 0; host_rd = 1; #0.5;
        check("R13 rd only", {7'd0, host_bus_dir}, 8'h00);
        host_rd = 0;
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_ctrl();
                t_data();
                t_status();
                t_irq();
                t_busdir();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule